// File: doc/BRIEF.md
# Sparse Transition Capture Recorder

The recorder watches three single-bit logic inputs and keeps a log of the moments they change. It does not keep a sample for every tick. It writes an entry only in a tick where at least one input differs from the value seen on the previous tick. Each entry holds the three input levels after the change and a wrapping timestamp that counts sample ticks since the run started. Runs with few changes can therefore last for minutes while keeping one-tick resolution. At the default settings (a 250 MHz clock and a 250-clock tick) one tick is one microsecond.

A run goes through three steps. An arm pulse readies the block. The run starts on a chosen edge of channel 0, and that edge becomes entry zero with timestamp zero. The run stops when the event memory is full or when an abort pulse arrives. The done flag then rises, and the entries stay readable through an address/data read port until the next arm. Converting the timestamps to intervals is left to the unloader.

Top module: `transition_logger`

## Requirements
- R1: Each input passes through two flip-flops. The synchronised vector is compared against the vector taken on the previous sample tick. A tick occurs once every TICK_DIV clocks, and one tick is one timestamp unit.
- R2: An arm pulse while not busy sets busy, clears evt_count to 0 and clears done. An arm pulse while busy has no effect.
- R3: While armed, the run starts only on a rising edge of ch_in[0] (trig_falling=0) or on a falling edge of ch_in[0] (trig_falling=1). An edge of the opposite direction, or a change on ch_in[1] or ch_in[2], stores nothing.
- R4: The trigger edge is stored at address 0 with timestamp 0. Every entry reads as rd_data = {levels ch[2:0] in bits TS_W+2..TS_W, timestamp in bits TS_W-1..0}.
- R5: After the trigger, each tick in which any channel changed stores the new levels and the number of ticks since the trigger at the next address, and increments evt_count.
- R6: A tick in which no channel changed stores nothing, and evt_count is unchanged.
- R7: The timestamp is TS_W bits wide (default 21) and wraps modulo 2^TS_W.
- R8: Writing entry number DEPTH (default 510) ends the run: busy falls and done rises. Later changes are not stored.
- R9: An abort pulse while armed or running ends the run at once with done set. evt_count and the stored entries are kept.
- R10: After reset, busy, done and evt_count are all 0.
- R11: done and evt_count hold their values while idle until the next arm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm | input | 1 | Pulse: prepare a run and wait for the trigger |
| abort | input | 1 | Pulse: stop the current run early |
| trig_falling | input | 1 | Trigger edge select on channel 0: 0 rising, 1 falling |
| ch_in | input | 3 | Asynchronous logic inputs to monitor |
| busy | output | 1 | Armed or running |
| done | output | 1 | Last run finished (full or aborted) |
| evt_count | output | 10 | Number of entries stored in the current or last run |
| rd_addr | input | 9 | Entry address for the unloader |
| rd_data | output | TS_W+3 | Entry at rd_addr: levels above timestamp |

## Verification
The bench runs three scenarios, and each one separates a different class of fault.

- **Mixed-channel run with a rising trigger.** Changes on channels 1 and 2 occur before the trigger, then quiet ticks, then a gap longer than the timestamp range. This separates fault types:
  - storing before the trigger versus waiting correctly;
  - writing on quiet ticks versus skipping them;
  - saturating the timestamp versus wrapping it.
- **Run with a falling trigger.** A rising edge on channel 0 comes first. This shows whether the edge select is honoured or the block starts on any change.
- **Single-channel toggle run.** One channel toggles every tick until the memory fills, followed by one more toggle. This pins down the exact stop count and shows whether writing stops once the memory is full.

Abort and arm pulses are also placed mid-run, to show that stored data is kept after an abort and that a re-arm is ignored while busy.

// File: rtl/transition_logger.sv
module transition_logger #(
  parameter int TS_W     = 21,
  parameter int DEPTH    = 510,
  parameter int TICK_DIV = 250,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH) + 1,
  localparam int EW = TS_W + 3,
  localparam int DW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic          abort,
  input  logic          trig_falling,
  input  logic [2:0]    ch_in,
  output logic          busy,
  output logic          done,
  output logic [CW-1:0] evt_count,
  input  logic [AW-1:0] rd_addr,
  output logic [EW-1:0] rd_data
);

  typedef enum logic [1:0] {IDLE, ARMED, RUN} state_t;

  state_t          state;
  logic [2:0]      sync1, sync2, prev;
  logic [DW-1:0]   div;
  logic [TS_W-1:0] ts;
  logic [CW-1:0]   count;
  logic [EW-1:0]   mem [DEPTH];

  wire tick     = (div == DW'(TICK_DIV - 1));
  wire changed  = tick && (sync2 != prev);
  wire trig_hit = tick && (trig_falling ? (prev[0] & ~sync2[0]) : (~prev[0] & sync2[0]));
  wire is_last  = (count == CW'(DEPTH - 1));
  wire wr_trig  = (state == ARMED) && trig_hit && !abort;
  wire wr_run   = (state == RUN) && changed && !abort;
  wire wr_en    = wr_trig || wr_run;
  wire [EW-1:0] wr_data = {sync2, wr_trig ? {TS_W{1'b0}} : ts};

  assign busy      = (state != IDLE);
  assign evt_count = count;
  assign rd_data   = mem[rd_addr];

  always_ff @(posedge clk) begin
    if (wr_en) mem[count[AW-1:0]] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= IDLE;
      sync1 <= '0;
      sync2 <= '0;
      prev  <= '0;
      div   <= '0;
      ts    <= '0;
      count <= '0;
      done  <= 1'b0;
    end else begin
      sync1 <= ch_in;
      sync2 <= sync1;
      div   <= tick ? '0 : div + 1'b1;
      if (tick) prev <= sync2;
      case (state)
        IDLE: if (arm) begin
          state <= ARMED;
          count <= '0;
          done  <= 1'b0;
        end
        ARMED: if (abort) begin
          state <= IDLE;
          done  <= 1'b1;
        end else if (trig_hit) begin
          state <= RUN;
          count <= CW'(1);
          ts    <= TS_W'(1);
        end
        RUN: if (abort) begin
          state <= IDLE;
          done  <= 1'b1;
        end else if (tick) begin
          ts <= ts + 1'b1;
          if (changed) begin
            count <= count + 1'b1;
            if (is_last) begin
              state <= IDLE;
              done  <= 1'b1;
            end
          end
        end
        default: state <= IDLE;
      endcase
    end
  end

  // R8
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  // R8 R9
  done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(abort) || count == CW'(DEPTH)));

  // R2
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  // R6
  quiet_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RUN && tick && sync2 == prev && !abort) |=> $stable(count));

  // R4
  trig_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_trig |=> (count == CW'(1) && state == RUN));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy) && !$past(arm)) |-> ($stable(count) && $stable(done)));

endmodule

// File: tb/test_transition_logger.sv
`timescale 1ns/1ps
module test_transition_logger;
  localparam int TS_W = 10, DEPTH = 510, DIV = 4, EW = TS_W + 3;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, arm = 1'b0, abort = 1'b0, trig_falling = 1'b0;
  logic [2:0] ch_in = 3'b000;
  logic busy, done;
  logic [9:0] evt_count;
  logic [8:0] rd_addr = '0;
  logic [EW-1:0] rd_data;

  transition_logger #(.TS_W(TS_W), .DEPTH(DEPTH), .TICK_DIV(DIV)) i_transition_logger (
    .clk(clk), .rst_n(rst_n), .arm(arm), .abort(abort), .trig_falling(trig_falling),
    .ch_in(ch_in), .busy(busy), .done(done), .evt_count(evt_count),
    .rd_addr(rd_addr), .rd_data(rd_data));

  int checks = 0, fails = 0;
  logic [EW-1:0] exp_q[$];
  logic [2:0] lv = 3'b000;
  int tk = 0, pushed = 0, last_cnt = 0;
  bit rec = 0;

  task automatic check(input string tag, input longint act, input longint expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // driver: change inputs, predict stored entry, hold n ticks
  task automatic step(input logic [2:0] v, input int n);
    @(negedge clk);
    ch_in = v;
    if (rec && v != lv && pushed < DEPTH) begin
      exp_q.push_back({v, TS_W'(tk)});
      pushed++;
    end
    lv = v;
    repeat (n * DIV - 1) @(negedge clk);
    tk += n;
  endtask

  task automatic trigger(input logic [2:0] v, input int n);
    rec = 1; pushed = 0; tk = 0;
    step(v, n);
  endtask

  task automatic pulse(input bit a, input bit b);
    @(negedge clk);
    arm = a; abort = b;
    @(negedge clk);
    arm = 0; abort = 0;
    repeat (DIV - 2) @(negedge clk);
    tk += 1;
  endtask

  // monitor: read each new entry as the count grows
  always @(negedge clk) begin
    if (evt_count == 0) last_cnt = 0;
    else if (int'(evt_count) > last_cnt) begin
      rd_addr = 9'(last_cnt);
      #1;
      if (exp_q.size() == 0) check("R5 unexpected entry", rd_data, 0);
      else check("R1/R4/R5/R7 entry", rd_data, exp_q.pop_front());
      last_cnt++;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    repeat (5) @(negedge clk);
    check("R10 busy", busy, 0);
    check("R10 done", done, 0);
    check("R10 count", evt_count, 0);
    rst_n = 1'b1;
    step(3'b010, 3);
    check("R3 idle change stores nothing", evt_count, 0);

    // run 1: rising trigger
    pulse(1, 0);
    check("R2 busy after arm", busy, 1);
    check("R2 done after arm", done, 0);
    step(3'b110, 2);
    step(3'b100, 2);
    check("R3 other channels no start", evt_count, 0);
    check("R3 still armed", busy, 1);
    trigger(3'b101, 2);
    check("R4 trigger entry count", evt_count, 1);
    step(3'b111, 3);
    step(3'b011, 1);
    step(3'b011, 5);
    check("R6 quiet ticks store nothing", evt_count, 3);
    pulse(1, 0);
    check("R2 arm ignored while busy count", evt_count, 3);
    check("R2 arm ignored while busy", busy, 1);
    step(3'b010, 1030);
    step(3'b000, 2);
    check("R7 count after wrap gap", evt_count, 5);
    pulse(0, 1);
    rec = 0;
    check("R9 done after abort", done, 1);
    check("R9 busy after abort", busy, 0);
    check("R9 count kept", evt_count, 5);
    step(3'b111, 2);
    check("R9 no store after abort", evt_count, 5);
    rd_addr = 9'd0; #1;
    check("R9 R4 entry 0 kept", rd_data, {3'b101, TS_W'(0)});

    // run 2: falling trigger
    trig_falling = 1'b1;
    step(3'b110, 2);
    pulse(1, 0);
    step(3'b111, 2);
    check("R3 wrong edge no start", evt_count, 0);
    trigger(3'b110, 2);
    step(3'b100, 1);
    step(3'b101, 2);
    check("R3 falling trigger run count", evt_count, 3);
    pulse(0, 1);
    rec = 0;
    check("R9 abort count", evt_count, 3);
    step(3'b000, 4);
    check("R11 done held", done, 1);
    check("R11 count held", evt_count, 3);

    // run 3: fill memory
    trig_falling = 1'b0;
    pulse(1, 0);
    check("R2 count cleared on arm", evt_count, 0);
    check("R2 done cleared on arm", done, 0);
    step(3'b000, 2);
    trigger(3'b001, 1);
    for (int i = 0; i < DEPTH - 1; i++) step((i % 2 == 0) ? 3'b011 : 3'b001, 1);
    step(lv, 2);
    check("R8 count at full", evt_count, DEPTH);
    check("R8 done at full", done, 1);
    check("R8 busy at full", busy, 0);
    step(~lv, 3);
    check("R8 no store after full", evt_count, DEPTH);
    check("R5 all entries seen", exp_q.size(), 0);
    summary();
  end
endmodule